// File: doc/BRIEF.md
# Unanchored Regex Match Engine (One-Hot NFA Chain)

This block searches a byte stream for one fixed regular expression, `hac?k{1,2}er[0-9]*(\s*tcp|udp)+`. It searches without an anchor, so a match can begin at any position in the stream. Each character position of the expression is a one-bit state cell. A cell becomes active when at least one of its predecessor cells was active and the current byte satisfies the cell's label. All operators of the expression are pure wiring between identical cells: the optional `c`, the bounded `k{1,2}`, the starred digit run, the starred whitespace run, the two-way union and the one-or-more group.

Literal labels are compared locally against the incoming byte. The two class labels (digit, whitespace) are not decoded inside the block. They are taken from an external classification bus that an upstream classifier drives alongside each byte. A byte is consumed only while its valid strobe is high. The match flag is the OR of the two accepting state registers. It therefore reports, one clock after a byte is taken, whether the text consumed so far ends in a match.

Top module: `regex_nfa_chain`

## Requirements
- R1: A synchronous reset clears every state register. `match_o` is low in the cycle after reset and stays low until a complete match is consumed after reset, so a partial match made before reset is forgotten.
- R2: While `char_vld_i` is low, no state changes and `match_o` holds its value, whatever `char_i` and `class_i` carry.
- R3: A state cell turns on only in a cycle where a byte is taken, its label matches that byte and at least one predecessor state was active. A taken byte that fails the label or lacks an active predecessor leaves the cell off.
- R4: Every taken byte can start a new match attempt: the expression is found inside longer text, for example after other characters or after a repeated `h`.
- R5: The `c` after `ha` is optional. Zero or one `c` is accepted; two are not.
- R6: The `k` run accepts one or two copies and rejects three.
- R7: Zero or more digit positions may follow `er`. A byte is a digit when `class_i[0]` is 1.
- R8: The class positions obey only the classification bus. Bit 0 is the digit class and bit 1 is the whitespace class. A digit byte with bit 0 low does not advance, and any byte with bit 0 high does.
- R9: The group `(\s*tcp|udp)` repeats one or more times. Each completed repetition raises `match_o`, and `tcp` and `udp` may alternate in any order.
- R10: Whitespace (`class_i[1]` = 1) may precede `tcp` any number of times but may not precede `udp`.
- R11: `match_o` is high exactly in the cycle after the taken byte that completes `tcp` or `udp` as a valid match. It goes low after the next taken byte unless that byte also completes a match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| char_vld_i | input | 1 | High when `char_i`/`class_i` carry a byte to consume |
| char_i | input | CHAR_W | Stream byte, compared against literal labels |
| class_i | input | CLASS_W | Classification of `char_i`: bit 0 digit, bit 1 whitespace |
| match_o | output | 1 | Text consumed so far ends in a match of the expression |

## Verification
The critical coincidence is the same taken byte both ending one repetition of the group and entering the next. One case is the `p` of `udp` making `u` or `t` eligible on the following byte. Another is a whitespace byte that both extends the run and keeps the group entry alive. The bench provokes this with streams such as `hackerudpudp`, `hakkertcpudp` and `hackerudp tcp`. It judges every byte position against hand-derived match positions, so a missing feedback path shows up as an absent second pulse and a spurious bypass shows up as an extra one. A second coincidence arises when a new `h` starts a fresh attempt while an older attempt is still in flight. The repeated-`h` and prefixed-text vectors cover that case.

// File: rtl/regex_nfa_pkg.sv
package regex_nfa_pkg;

  localparam int NUM_STATES = 15;
  localparam int MAX_FANIN  = 6;
  localparam int CHAR_W     = 8;
  localparam int CLASS_W    = 2;

  localparam int CLS_DIGIT = 0;
  localparam int CLS_SPACE = 1;

  // State positions of hac?k{1,2}er[0-9]*(\s*tcp|udp)+
  localparam int ST_H    = 0;
  localparam int ST_A    = 1;
  localparam int ST_COPT = 2;
  localparam int ST_K1   = 3;
  localparam int ST_K2   = 4;
  localparam int ST_E    = 5;
  localparam int ST_R    = 6;
  localparam int ST_DIG  = 7;
  localparam int ST_WS   = 8;
  localparam int ST_T    = 9;
  localparam int ST_TC   = 10;
  localparam int ST_TP   = 11;
  localparam int ST_U    = 12;
  localparam int ST_UD   = 13;
  localparam int ST_UP   = 14;

  typedef enum logic {SRC_LOCAL = 1'b0, SRC_CLASS = 1'b1} hit_src_e;

  typedef struct packed {
    hit_src_e   src;
    logic [7:0] lit;
    logic [3:0] cls;
  } cell_cfg_t;

  typedef logic [NUM_STATES-1:0] state_vec_t;
  typedef logic [MAX_FANIN-1:0]  fanin_t;

  function automatic cell_cfg_t cell_cfg(input int idx);
    cell_cfg_t c;
    c.src = SRC_LOCAL;
    c.cls = 4'd0;
    case (idx)
      ST_H:    c.lit = 8'h68; // h
      ST_A:    c.lit = 8'h61; // a
      ST_COPT: c.lit = 8'h63; // c
      ST_K1:   c.lit = 8'h6B; // k
      ST_K2:   c.lit = 8'h6B; // k
      ST_E:    c.lit = 8'h65; // e
      ST_R:    c.lit = 8'h72; // r
      ST_T:    c.lit = 8'h74; // t
      ST_TC:   c.lit = 8'h63; // c
      ST_TP:   c.lit = 8'h70; // p
      ST_U:    c.lit = 8'h75; // u
      ST_UD:   c.lit = 8'h64; // d
      ST_UP:   c.lit = 8'h70; // p
      ST_DIG: begin c.lit = 8'h00; c.src = SRC_CLASS; c.cls = 4'(CLS_DIGIT); end
      default: begin c.lit = 8'h00; c.src = SRC_CLASS; c.cls = 4'(CLS_SPACE); end
    endcase
    return c;
  endfunction

  function automatic state_vec_t accept_mask();
    state_vec_t m;
    m = '0;
    m[ST_TP] = 1'b1;
    m[ST_UP] = 1'b1;
    return m;
  endfunction

  // Bounded repetition k{1,2}: the last n-m+1 = 2 copies may exit.
  function automatic logic k_exit(input state_vec_t s);
    return s[ST_K1] | s[ST_K2];
  endfunction

  // Star: exit either from the state before it (bypass) or from its own cell.
  function automatic logic digit_exit(input state_vec_t s);
    return s[ST_R] | s[ST_DIG];
  endfunction

  // One-or-more group: entered from the digit run or fed back from its exits.
  function automatic logic group_entry(input state_vec_t s);
    return digit_exit(s) | s[ST_TP] | s[ST_UP];
  endfunction

  function automatic fanin_t fanin_of(input int idx, input state_vec_t s, input logic start);
    fanin_t f;
    f = '0;
    case (idx)
      ST_H:    f[0]   = start;
      ST_A:    f[0]   = s[ST_H];
      ST_COPT: f[0]   = s[ST_A];
      ST_K1:   f[1:0] = {s[ST_COPT], s[ST_A]};
      ST_K2:   f[0]   = s[ST_K1];
      ST_E:    f[0]   = k_exit(s);
      ST_R:    f[0]   = s[ST_E];
      ST_DIG:  f[1:0] = {s[ST_DIG], s[ST_R]};
      ST_WS:   f[1:0] = {s[ST_WS], group_entry(s)};
      ST_T:    f[1:0] = {s[ST_WS], group_entry(s)};
      ST_TC:   f[0]   = s[ST_T];
      ST_TP:   f[0]   = s[ST_TC];
      ST_U:    f[0]   = group_entry(s);
      ST_UD:   f[0]   = s[ST_U];
      default: f[0]   = s[ST_UD];
    endcase
    return f;
  endfunction

endpackage

// File: rtl/rnfa_hit_sel.sv
module rnfa_hit_sel #(
  parameter int              CHAR_W    = 8,
  parameter int              CLASS_W   = 2,
  parameter bit              USE_CLASS = 1'b0,
  parameter logic [CHAR_W-1:0] LIT     = '0,
  parameter int              CLS_IDX   = 0
) (
  input  logic [CHAR_W-1:0]  char_i,
  input  logic [CLASS_W-1:0] class_i,
  output logic               hit_o
);
  logic lit_hit_w;
  logic cls_hit_w;

  assign lit_hit_w = (char_i == LIT);
  assign cls_hit_w = class_i[CLS_IDX];
  assign hit_o     = USE_CLASS ? cls_hit_w : lit_hit_w;

  initial begin
    assert (CLS_IDX < CLASS_W) else $error("class index out of range");
  end
endmodule

// File: rtl/rnfa_route.sv
module rnfa_route
  import regex_nfa_pkg::*;
#(
  parameter int NS = NUM_STATES,
  parameter int FW = MAX_FANIN
) (
  input  logic [NS-1:0]         state_i,
  input  logic                  start_i,
  output logic [NS-1:0][FW-1:0] fanin_o
);
  always_comb begin
    for (int i = 0; i < NS; i++) begin
      fanin_o[i] = fanin_of(i, state_i, start_i);
    end
  end
endmodule

// File: rtl/rnfa_state_cell.sv
module rnfa_state_cell #(
  parameter int FANIN_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               adv_i,
  input  logic [FANIN_W-1:0] fanin_i,
  input  logic               hit_i,
  output logic               state_o
);
  logic enter_w;
  logic set_w;
  logic state_q;

  assign enter_w = |fanin_i;
  assign set_w   = enter_w & hit_i;

  always_ff @(posedge clk_i) begin
    if (rst_i)      state_q <= 1'b0;
    else if (adv_i) state_q <= set_w;
  end

  assign state_o = state_q;

  // R1: reset clears the cell
  p_reset_clear_r1: assert property (@(posedge clk_i) rst_i |=> !state_o);
  // R2: no taken byte, no change
  p_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !adv_i |=> $stable(state_o));
  // R3: label mismatch leaves the cell off
  p_gate_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv_i && !hit_i) |=> !state_o);
  // R3: no active predecessor leaves the cell off
  p_fanin_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv_i && !enter_w) |=> !state_o);
endmodule

// File: rtl/regex_nfa_chain.sv
module regex_nfa_chain
  import regex_nfa_pkg::*;
#(
  parameter int CHAR_W  = regex_nfa_pkg::CHAR_W,
  parameter int CLASS_W = regex_nfa_pkg::CLASS_W
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               char_vld_i,
  input  logic [CHAR_W-1:0]  char_i,
  input  logic [CLASS_W-1:0] class_i,
  output logic               match_o
);
  localparam int NS = NUM_STATES;
  localparam int FW = MAX_FANIN;
  localparam logic [NS-1:0] ACCEPT = accept_mask();

  logic [NS-1:0]         state_w;
  logic [NS-1:0]         hit_w;
  logic [NS-1:0][FW-1:0] fanin_w;
  logic                  start_w;

  // Unanchored search: a new attempt may begin at every taken byte.
  assign start_w = 1'b1;

  rnfa_route #(.NS(NS), .FW(FW)) u_route (
    .state_i (state_w),
    .start_i (start_w),
    .fanin_o (fanin_w)
  );

  for (genvar g = 0; g < NS; g++) begin : g_cell
    localparam cell_cfg_t CFG = cell_cfg(g);

    rnfa_hit_sel #(
      .CHAR_W    (CHAR_W),
      .CLASS_W   (CLASS_W),
      .USE_CLASS (CFG.src == SRC_CLASS),
      .LIT       (CHAR_W'(CFG.lit)),
      .CLS_IDX   (int'(CFG.cls))
    ) u_hit (
      .char_i  (char_i),
      .class_i (class_i),
      .hit_o   (hit_w[g])
    );

    rnfa_state_cell #(.FANIN_W(FW)) u_cell (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .adv_i   (char_vld_i),
      .fanin_i (fanin_w[g]),
      .hit_i   (hit_w[g]),
      .state_o (state_w[g])
    );
  end

  assign match_o = |(state_w & ACCEPT);

  // R2: match flag frozen while no byte is taken
  p_match_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !char_vld_i |=> $stable(match_o));
  // R4: a taken 'h' always opens an attempt
  p_start_any_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (char_vld_i && char_i == CHAR_W'(8'h68)) |=> state_w[ST_H]);
  // R5: the optional c is entered only straight after 'a'
  p_opt_c_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(char_vld_i) && state_w[ST_COPT]) |-> $past(state_w[ST_A]));
  // R6: second k only directly after the first
  p_k_pair_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(char_vld_i) && state_w[ST_K2]) |-> $past(state_w[ST_K1]));
  // R11: match only rises on a taken byte
  p_match_rise_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(match_o) |-> $past(char_vld_i));
endmodule

// File: tb/test_regex_nfa_chain.sv
`timescale 1ns/1ps
module test_regex_nfa_chain;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vld = 1'b0;
  logic [7:0] ch  = 8'h00;
  logic [1:0] cls = 2'b00;
  logic       match;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  regex_nfa_chain i_regex_nfa_chain (
    .clk_i(clk), .rst_i(rst), .char_vld_i(vld),
    .char_i(ch), .class_i(cls), .match_o(match)
  );

  typedef struct packed {
    logic [127:0] txt;
    int           len;
    logic [15:0]  exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{"hacker12 tcp",    12, 16'h0800},
    '{"hackerudpudp",    12, 16'h0900},
    '{"hakertcp",         8, 16'h0080},
    '{"hacckertcp",      10, 16'h0000},
    '{"hakkkerudp",      10, 16'h0000},
    '{"hakkertcpudp",    12, 16'h0900},
    '{"xxhacker  tcp",   13, 16'h1000},
    '{"hacker5 udp",     11, 16'h0000},
    '{"hhacker99udptcp", 15, 16'h4800},
    '{"hackertcpx tcp",  14, 16'h0100},
    '{"hackerudp tcp",   13, 16'h1100}
  };

  // bit0 digit, bit1 whitespace
  function automatic logic [1:0] class_of(input logic [7:0] c);
    logic sp, dg;
    sp = (c == 8'h20) || (c == 8'h09) || (c == 8'h0A) || (c == 8'h0D);
    dg = (c >= 8'h30) && (c <= 8'h39);
    return {sp, dg};
  endfunction

  task automatic push(input logic [7:0] c, input logic [1:0] cl, input logic v);
    vld = v; ch = c; cls = cl;
    @(posedge clk);
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic feed(input logic [127:0] t, input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] c;
      c = t[8*(n-1-i) +: 8];
      push(c, class_of(c), 1'b1);
    end
  endtask

  task automatic chk(input logic exp, input string req);
    n_cmp++;
    if (match !== exp) begin
      n_bad++;
      $display("FAIL %s: match_o=%b expected %b at %0t", req, match, exp, $time);
    end
  endtask

  initial begin : watchdog
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(1'b0, "R1 reset");

    // Table: every byte position checked (R3..R11)
    for (int v = 0; v < NV; v++) begin
      push(8'h23, 2'b00, 1'b1); // '#' flushes all attempts
      chk(1'b0, "R11 flush");
      for (int i = 0; i < VECS[v].len; i++) begin
        logic [7:0] c;
        c = VECS[v].txt[8*(VECS[v].len-1-i) +: 8];
        push(c, class_of(c), 1'b1);
        chk(VECS[v].exp[i], $sformatf("R9/R10/R5/R6/R4 vec%0d pos%0d", v, i));
      end
    end

    // R2: idle bytes with garbage are ignored, match held
    push(8'h23, 2'b00, 1'b1);
    feed("haker", 5);
    for (int k = 0; k < 4; k++) begin
      push(8'h78, 2'b11, 1'b0);
      chk(1'b0, "R2 idle no advance");
    end
    feed("tcp", 3);
    chk(1'b1, "R2 idle state kept");
    for (int k = 0; k < 3; k++) begin
      push(8'h23, 2'b00, 1'b0);
      chk(1'b1, "R2 match held");
    end
    push(8'h23, 2'b00, 1'b1);
    chk(1'b0, "R11 match falls");

    // R8: digit byte with class bit low does not advance
    feed("hacker", 6);
    push(8'h35, 2'b00, 1'b1);
    feed("udp", 3);
    chk(1'b0, "R8 digit without class");
    // R8/R7: any byte with digit class bit advances
    push(8'h23, 2'b00, 1'b1);
    feed("hacker", 6);
    push(8'h7A, 2'b01, 1'b1);
    feed("udp", 3);
    chk(1'b1, "R7 class digit");

    // R10: tab flagged as whitespace before tcp
    push(8'h23, 2'b00, 1'b1);
    feed("hacker", 6);
    push(8'h09, 2'b10, 1'b1);
    chk(1'b0, "R10 ws alone");
    feed("tcp", 3);
    chk(1'b1, "R10 ws before tcp");
    // R8: space without whitespace class bit blocks tcp
    push(8'h23, 2'b00, 1'b1);
    feed("hacker", 6);
    push(8'h20, 2'b00, 1'b1);
    feed("tcp", 3);
    chk(1'b0, "R8 space without class");

    // R1: reset mid-stream forgets partial match
    push(8'h23, 2'b00, 1'b1);
    feed("haker", 5);
    rst = 1'b1;
    push(8'h00, 2'b00, 1'b0);
    rst = 1'b0;
    chk(1'b0, "R1 reset mid-stream");
    feed("tcp", 3);
    chk(1'b0, "R1 partial forgotten");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule